// File: doc/BRIEF.md
# Calendar-Overlaid Byte Memory

This block is a 2048-byte static memory behind a plain byte bus. The bus has an active-low chip select, an active-low output enable and an active-low write enable. Writes happen at the rising clock edge. Read data is combinational, and a data-valid flag stands in for the tri-state pad enable. The eight highest addresses do not hold ordinary storage. They hold a real-time calendar that advances on a one-second tick input and counts in packed BCD with 24-hour time. The calendar handles 28-, 29-, 30- and 31-day months, including February of leap years.

Software sets the time in three steps. It sets the hold bit in the control byte, writes the calendar bytes, and then clears the hold bit. It reads a coherent multi-byte time by setting the capture bit, reading the calendar bytes, and then clearing the capture bit. A power-fail input forces the bus into the deselected state.

Top module: `calendar_sram`

## Requirements
- R1: While `ce_n` is 1 the bus is deselected: `dout_en` is 0, and a write strobe leaves memory and calendar unchanged.
- R2: With `ce_n`=0 and `we_n`=0, and `pwr_fail`=0, `din` is stored at `addr` at the rising clock edge. This holds whatever the level of `oe_n`.
- R3: With `ce_n`=0, `we_n`=1 and `oe_n`=0 (and `pwr_fail`=0), `dout_en` is 1 and `dout` shows the addressed byte. When `oe_n`=1, `dout_en` is 0.
- R4: Addresses 0x000 to 0x7F7 are plain storage. A written byte reads back unchanged and does not disturb other addresses.
- R5: While `pwr_fail` is 1, `dout_en` is 0 and bus writes are ignored.
- R6: The calendar bytes are mapped as follows. Seconds is at 0x7F9, minutes at 0x7FA and hours at 0x7FB, all in BCD. On each tick, seconds go from 0x59 to 0x00 with a carry into minutes, and minutes carry the same way into hours. Hours go from 0x23 to 0x00 with a carry into the day.
- R7: Day of week is at 0x7FC and runs from 1 to 7. It advances at midnight and goes from 7 back to 1.
- R8: Date is at 0x7FD (BCD 01 to 31), month at 0x7FE (BCD 01 to 12) and year at 0x7FF (BCD 00 to 99). April, June, September and November have 30 days; the other months, February aside, have 31. December 31 rolls to January 1 with the year incremented, and year 0x99 wraps to 0x00.
- R9: February has 29 days when the year value is divisible by 4, and year 00 counts as divisible. In all other years it has 28 days.
- R10: The control byte is at 0x7F8. While its bit 7 is 1, ticks are ignored and the calendar holds its value.
- R11: While control bit 6 is 1, reads of 0x7F9 to 0x7FF return the values held just before the write that set the bit. Counting continues underneath, and clearing the bit exposes the live values.
- R12: When a tick arrives in the same cycle as a calendar write, the tick is applied to the written value. For example, writing seconds 0x59 together with a tick yields seconds 0x00 with a carry into minutes.
- R13: After reset the control byte is 0x00, the time is 00:00:00, the day of week is 1, the date is 01, the month is 01 and the year is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the calendar |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data valid (pad drive enable) |
| sec_tick | input | 1 | One-cycle pulse per second |
| pwr_fail | input | 1 | Supply-low indication; forces deselect |

## Verification
A bus write to a calendar byte and a one-second tick can land on the same clock edge. Both update the same counter registers, so the order in which they apply decides the result. The bench provokes this by asserting `sec_tick` in the same cycle as a write of 0x59 to the seconds byte, with minutes preset. It then reads back seconds and minutes and expects the tick to have acted on the written value: seconds 0x00 and minutes incremented by one. A second overlap is a tick arriving while the capture bit holds the readout. There the bench expects the frozen read values and, once the bit is cleared, the fully advanced count.

// File: rtl/calendar_sram.sv
module calendar_sram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  input  logic          sec_tick,
  input  logic          pwr_fail
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] ctrl_q, sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q;
  logic [7:0] s_sec, s_min, s_hr, s_dow, s_date, s_mon, s_yr;
  logic [7:0] n_ctrl, n_sec, n_min, n_hr, n_dow, n_date, n_mon, n_yr;
  logic [7:0] clk_rd;
  logic       c_s, c_m, c_h, c_d, c_mo;

  wire       is_clk = &addr[AW-1:3];
  wire [2:0] idx    = addr[2:0];
  wire       wr_en  = !ce_n && !we_n && !pwr_fail;
  wire       wr_clk = wr_en && is_clk;
  wire       snap   = ctrl_q[6];

  function automatic logic [7:0] binc(input logic [7:0] v);
    binc = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] yb;
    yb = ({4'd0, y[7:4]} << 3) + ({4'd0, y[7:4]} << 1) + {4'd0, y[3:0]};
    case (m)
      8'h02:                      last_day = (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  endfunction

  always_ff @(posedge clk)
    if (wr_en && !is_clk) mem[addr] <= din;

  always_comb begin
    n_ctrl = ctrl_q; n_sec = sec_q; n_min = min_q; n_hr = hr_q;
    n_dow = dow_q; n_date = date_q; n_mon = mon_q; n_yr = yr_q;
    c_s = 1'b0; c_m = 1'b0; c_h = 1'b0; c_d = 1'b0; c_mo = 1'b0;
    if (wr_clk) begin
      case (idx)
        3'd0: n_ctrl = din;
        3'd1: n_sec  = din;
        3'd2: n_min  = din;
        3'd3: n_hr   = din;
        3'd4: n_dow  = din;
        3'd5: n_date = din;
        3'd6: n_mon  = din;
        default: n_yr = din;
      endcase
    end
    if (sec_tick && !n_ctrl[7]) begin
      c_s   = (n_sec == 8'h59);
      n_sec = c_s ? 8'h00 : binc(n_sec);
      if (c_s) begin
        c_m   = (n_min == 8'h59);
        n_min = c_m ? 8'h00 : binc(n_min);
      end
      if (c_m) begin
        c_h  = (n_hr == 8'h23);
        n_hr = c_h ? 8'h00 : binc(n_hr);
      end
      if (c_h) begin
        n_dow  = (n_dow >= 8'h07) ? 8'h01 : n_dow + 8'h01;
        c_d    = (n_date >= last_day(n_mon, n_yr));
        n_date = c_d ? 8'h01 : binc(n_date);
      end
      if (c_d) begin
        c_mo  = (n_mon >= 8'h12);
        n_mon = c_mo ? 8'h01 : binc(n_mon);
      end
      if (c_mo) n_yr = (n_yr == 8'h99) ? 8'h00 : binc(n_yr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00; sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      dow_q  <= 8'h01; date_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00;
      s_sec  <= 8'h00; s_min <= 8'h00; s_hr <= 8'h00; s_dow <= 8'h01;
      s_date <= 8'h01; s_mon <= 8'h01; s_yr <= 8'h00;
    end else begin
      ctrl_q <= n_ctrl; sec_q <= n_sec; min_q <= n_min; hr_q <= n_hr;
      dow_q  <= n_dow; date_q <= n_date; mon_q <= n_mon; yr_q <= n_yr;
      if (!snap) begin
        s_sec <= sec_q; s_min <= min_q; s_hr <= hr_q; s_dow <= dow_q;
        s_date <= date_q; s_mon <= mon_q; s_yr <= yr_q;
      end
    end
  end

  always_comb begin
    case (idx)
      3'd0: clk_rd = ctrl_q;
      3'd1: clk_rd = snap ? s_sec  : sec_q;
      3'd2: clk_rd = snap ? s_min  : min_q;
      3'd3: clk_rd = snap ? s_hr   : hr_q;
      3'd4: clk_rd = snap ? s_dow  : dow_q;
      3'd5: clk_rd = snap ? s_date : date_q;
      3'd6: clk_rd = snap ? s_mon  : mon_q;
      default: clk_rd = snap ? s_yr : yr_q;
    endcase
  end

  assign dout    = is_clk ? clk_rd : mem[addr];
  assign dout_en = !ce_n && we_n && !oe_n && !pwr_fail;
endmodule

// File: rtl/calendar_sram_chk.sv
module calendar_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       pwr_fail,
  input logic       sec_tick,
  input logic       dout_en,
  input logic       wr_clk,
  input logic [7:0] ctrl_q,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] s_sec
);
  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);
  assert_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && !pwr_fail) |-> (dout_en == !oe_n));
  assert_pwrfail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> !dout_en);
  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q == 8'h59 && sec_tick && !ctrl_q[7] && !wr_clk) |=> (sec_q == 8'h00));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && !wr_clk) |=> ($stable(sec_q) && $stable(min_q)));
  assert_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !wr_clk) |=> $stable(s_sec));
endmodule

bind calendar_sram calendar_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .pwr_fail(pwr_fail), .sec_tick(sec_tick), .dout_en(dout_en),
  .wr_clk(wr_clk), .ctrl_q(ctrl_q), .sec_q(sec_q), .min_q(min_q), .s_sec(s_sec)
);

// File: tb/sim_calendar_sram.sv
module sim_calendar_sram;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, sec_tick = 0, pwr_fail = 0;
  logic [10:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_en;
  int checks = 0, errors = 0;

  calendar_sram u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .sec_tick(sec_tick), .pwr_fail(pwr_fail));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d, output logic en);
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 0; addr = a; #1;
    d = dout; en = dout_en;
  endtask

  task automatic expect_rd(input string req, input logic [10:0] a, input logic [7:0] e);
    logic [7:0] d; logic en;
    rd(a, d, en);
    chk(req, {7'd0, en}, 8'd1);
    chk(req, d, e);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
    end
  endtask

  task automatic set_clock(input logic [7:0] y, mo, dt, dw, h, mi, s);
    wr(11'h7F8, 8'h80);
    wr(11'h7F9, s); wr(11'h7FA, mi); wr(11'h7FB, h); wr(11'h7FC, dw);
    wr(11'h7FD, dt); wr(11'h7FE, mo); wr(11'h7FF, y);
    wr(11'h7F8, 8'h00);
  endtask

  task automatic t_reset;
    expect_rd("R13 ctrl", 11'h7F8, 8'h00);
    expect_rd("R13 sec", 11'h7F9, 8'h00);
    expect_rd("R13 hr", 11'h7FB, 8'h00);
    expect_rd("R13 dow", 11'h7FC, 8'h01);
    expect_rd("R13 date", 11'h7FD, 8'h01);
    expect_rd("R13 month", 11'h7FE, 8'h01);
    expect_rd("R13 year", 11'h7FF, 8'h00);
  endtask

  task automatic t_ram;
    wr(11'h000, 8'hA1); wr(11'h7F7, 8'h5C); wr(11'h2AB, 8'h3E);
    expect_rd("R4 low", 11'h000, 8'hA1);
    expect_rd("R4 top", 11'h7F7, 8'h5C);
    expect_rd("R4 mid", 11'h2AB, 8'h3E);
  endtask

  task automatic t_bus;
    logic [7:0] d; logic en;
    @(negedge clk); ce_n = 1; we_n = 0; oe_n = 0; addr = 11'h2AB; din = 8'hFF; #1;
    chk("R1 deselect en", {7'd0, dout_en}, 8'd0);
    @(negedge clk); we_n = 1;
    expect_rd("R1 write ignored", 11'h2AB, 8'h3E);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; addr = 11'h155; din = 8'h77;
    @(negedge clk); ce_n = 1; we_n = 1;
    expect_rd("R2 write with oe low", 11'h155, 8'h77);
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 1; addr = 11'h155; #1;
    chk("R3 oe high", {7'd0, dout_en}, 8'd0);
    rd(11'h155, d, en);
    chk("R3 read en", {7'd0, en}, 8'd1);
  endtask

  task automatic t_pwr;
    logic [7:0] d; logic en;
    pwr_fail = 1;
    wr(11'h155, 8'h12);
    rd(11'h155, d, en);
    chk("R5 bus off", {7'd0, en}, 8'd0);
    pwr_fail = 0;
    expect_rd("R5 write ignored", 11'h155, 8'h77);
  endtask

  task automatic t_time;
    set_clock(8'h25, 8'h03, 8'h10, 8'h03, 8'h23, 8'h59, 8'h58);
    ticks(1);
    expect_rd("R6 sec step", 11'h7F9, 8'h59);
    ticks(1);
    expect_rd("R6 sec wrap", 11'h7F9, 8'h00);
    expect_rd("R6 min wrap", 11'h7FA, 8'h00);
    expect_rd("R6 hr wrap", 11'h7FB, 8'h00);
    expect_rd("R6 date step", 11'h7FD, 8'h11);
    expect_rd("R7 dow step", 11'h7FC, 8'h04);
    set_clock(8'h25, 8'h03, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_rd("R7 dow wrap", 11'h7FC, 8'h01);
    set_clock(8'h25, 8'h03, 8'h10, 8'h02, 8'h09, 8'h09, 8'h59);
    ticks(1);
    expect_rd("R6 bcd carry", 11'h7FA, 8'h10);
  endtask

  task automatic t_months;
    set_clock(8'h25, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_rd("R8 30-day date", 11'h7FD, 8'h01);
    expect_rd("R8 30-day month", 11'h7FE, 8'h05);
    set_clock(8'h25, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_rd("R8 31-day no wrap", 11'h7FD, 8'h31);
    set_clock(8'h99, 8'h12, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_rd("R8 new year date", 11'h7FD, 8'h01);
    expect_rd("R8 new year month", 11'h7FE, 8'h01);
    expect_rd("R8 year wrap", 11'h7FF, 8'h00);
  endtask

  task automatic t_leap;
    set_clock(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_rd("R9 leap 29th", 11'h7FD, 8'h29);
    set_clock(8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_rd("R9 leap to march", 11'h7FE, 8'h03);
    set_clock(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_rd("R9 common date", 11'h7FD, 8'h01);
    expect_rd("R9 common month", 11'h7FE, 8'h03);
    set_clock(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_rd("R9 year 00 leap", 11'h7FD, 8'h29);
    set_clock(8'h10, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_rd("R9 year 10 common", 11'h7FE, 8'h03);
  endtask

  task automatic t_freeze;
    set_clock(8'h25, 8'h06, 8'h15, 8'h02, 8'h12, 8'h30, 8'h20);
    wr(11'h7F8, 8'h80);
    ticks(3);
    expect_rd("R10 held", 11'h7F9, 8'h20);
    wr(11'h7F8, 8'h00);
    ticks(2);
    expect_rd("R10 resumed", 11'h7F9, 8'h22);
  endtask

  task automatic t_snapshot;
    set_clock(8'h25, 8'h06, 8'h15, 8'h02, 8'h12, 8'h30, 8'h10);
    wr(11'h7F8, 8'h40);
    ticks(3);
    expect_rd("R11 frozen sec", 11'h7F9, 8'h10);
    expect_rd("R11 frozen min", 11'h7FA, 8'h30);
    wr(11'h7F8, 8'h00);
    expect_rd("R11 live after", 11'h7F9, 8'h13);
  endtask

  task automatic t_collide;
    set_clock(8'h25, 8'h06, 8'h15, 8'h02, 8'h12, 8'h20, 8'h30);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = 11'h7F9; din = 8'h59; sec_tick = 1;
    @(negedge clk); ce_n = 1; we_n = 1; sec_tick = 0;
    expect_rd("R12 sec after write+tick", 11'h7F9, 8'h00);
    expect_rd("R12 min carry", 11'h7FA, 8'h21);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_ram; t_bus; t_pwr; t_time; t_months; t_leap;
    t_freeze; t_snapshot; t_collide;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule